// File: doc/BRIEF.md
# Eight-Port Peripheral Bus Interface

This block sits on an 8-bit processor I/O bus that signals its cycles with an I/O-request strobe plus separate read and write strobes. It claims a window of eight consecutive port addresses. Four of these ports are active and four are decoded but left unused for later expansion. For every active port it gives a read select and a write select that the converter blocks outside can use. It also returns the read-back data and enables the external data transceiver on any card access.

Inside the block there are a digital output latch, a holding register for the DAC code and a two-stage synchronizer for an external 8-bit input. A write to port 0 issues a one-cycle start pulse to the ADC. A read of port 2 returns the ADC result. Every card access restarts a one-shot that lights an activity indicator for a parameter-set number of clock cycles.

Top module: `periph_bus_if`

## Requirements
- R1: The card window is the eight addresses `BASE_ADDR` to `BASE_ADDR+7`, and `addr[2:0]` gives the port offset. An access outside the window asserts no select and leaves `xcvr_en` low.
- R2: A read of offset i, for i from 0 to 3, asserts only `port_rd_sel[i]`. A write of offset i asserts only `port_wr_sel[i]`. An access to offsets 4 to 7 asserts no select.
- R3: Any card access makes `access_led` high after the next clock edge. The indicator stays high until `IND_CYCLES` edges have passed after the last edge that saw an access. A new access restarts this count.
- R4: `xcvr_en` is high, combinationally, for the whole of any card read or write, including accesses to offsets 4 to 7.
- R5: A write to offset 1 loads `wdata` into `dout` at the clock edge. `dout` keeps that value until the next write to offset 1.
- R6: A write to offset 0 makes `conv_start` high for exactly one cycle, right after the first edge of that write. A write to offset 2 loads `dac_data`.
- R7: A read returns, on `rdata`, the value set by the offset: offset 0 gives `dac_data`, offset 1 gives `dout`, and offset 2 gives `adc_result`.
- R8: A read of offset 3 returns `din_ext` as it was two clock edges earlier, passed through two flip-flops.
- R9: A read of offsets 4 to 7 returns 0xFF. `rdata` is also 0xFF whenever no card read is in progress.
- R10: The block decodes an access only while `io_req` is high and exactly one of `rd` and `wr` is high. Any other strobe combination selects nothing, enables nothing and loads nothing.
- R11: While reset is applied, `dout` and `dac_data` are 0 and `access_led` and `conv_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Bus I/O address |
| wdata | input | 8 | Bus write data |
| io_req | input | 1 | I/O request strobe, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| din_ext | input | 8 | External digital input, asynchronous |
| adc_result | input | 8 | Result from the ADC |
| rdata | output | 8 | Read-back data to the bus |
| xcvr_en | output | 1 | Data transceiver enable |
| port_rd_sel | output | 4 | Read select for each active port |
| port_wr_sel | output | 4 | Write select for each active port |
| conv_start | output | 1 | One-cycle ADC start pulse |
| dac_data | output | 8 | DAC code register |
| dout | output | 8 | Digital output latch |
| access_led | output | 1 | Access activity indicator |

## Verification
The assertions assume that the bus strobes, the address and the write data are synchronous to `clk` and stay steady for at least one whole clock cycle. They also assume that `adc_result` does not change while it is being read. The stimulus changes every bus input only on the falling edge and holds each bus cycle across one rising edge. It also tries the illegal strobe combinations, both strobes together and strobes without I/O request, so that the assertions guarding decode and latch hold are exercised on those cycles as well.

// File: rtl/periph_bus_if.sv
`timescale 1ns/1ps
module periph_bus_if #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'hA0,
  parameter int IND_CYCLES = 10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              io_req,
  input  logic              rd,
  input  logic              wr,
  input  logic [7:0]        din_ext,
  input  logic [7:0]        adc_result,
  output logic [7:0]        rdata,
  output logic              xcvr_en,
  output logic [3:0]        port_rd_sel,
  output logic [3:0]        port_wr_sel,
  output logic              conv_start,
  output logic [7:0]        dac_data,
  output logic [7:0]        dout,
  output logic              access_led
);
  localparam int OFF_W = 3;
  localparam int CNT_W = $clog2(IND_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(IND_CYCLES);

  logic [OFF_W-1:0] off;
  logic             hit, rd_hit, wr_hit;
  logic [7:0]       din_s1, din_s2;
  logic             wr0_q;
  logic [CNT_W-1:0] led_cnt;

  assign off    = addr[OFF_W-1:0];
  assign hit    = io_req && (rd ^ wr) && (addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
  assign rd_hit = hit && rd;
  assign wr_hit = hit && wr;
  assign xcvr_en = hit;

  for (genvar i = 0; i < 4; i++) begin : g_sel
    assign port_rd_sel[i] = rd_hit && (off == OFF_W'(i));
    assign port_wr_sel[i] = wr_hit && (off == OFF_W'(i));
  end

  always_comb begin
    rdata = 8'hFF;
    if (rd_hit) begin
      case (off)
        3'd0:    rdata = dac_data;
        3'd1:    rdata = dout;
        3'd2:    rdata = adc_result;
        3'd3:    rdata = din_s2;
        default: rdata = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= '0;
      dac_data   <= '0;
      din_s1     <= '0;
      din_s2     <= '0;
      wr0_q      <= 1'b0;
      conv_start <= 1'b0;
      led_cnt    <= '0;
    end else begin
      if (port_wr_sel[1]) dout <= wdata;
      if (port_wr_sel[2]) dac_data <= wdata;
      din_s1     <= din_ext;
      din_s2     <= din_s1;
      wr0_q      <= port_wr_sel[0];
      conv_start <= port_wr_sel[0] && !wr0_q;
      if (hit)               led_cnt <= CNT_LOAD;
      else if (led_cnt != 0) led_cnt <= led_cnt - 1'b1;
    end
  end

  assign access_led = (led_cnt != 0);

  assert_rd_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_rd_sel) && $onehot0(port_wr_sel));
  assert_sel_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd_sel != 0 || port_wr_sel != 0) |-> xcvr_en);
  assert_led_after_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_en |=> access_led);
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr_sel[1] |=> $stable(dout));
  assert_dac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr_sel[2] |=> $stable(dac_data));
  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_no_io_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_req || (rd && wr)) |-> (!xcvr_en && port_wr_sel == 0 && rdata == 8'hFF));
endmodule

// File: tb/test_periph_bus_if.sv
`timescale 1ns/1ps
module test_periph_bus_if;
  localparam int LED_N = 20;
  localparam int NV = 15;
  // {io, rd, wr, addr, wdata, exp_rd_sel, exp_wr_sel, exp_xcvr, exp_rdata}
  localparam logic [35:0] VEC [NV] = '{
    {3'b101, 8'hA2, 8'h3C, 4'b0000, 4'b0100, 1'b1, 8'hFF},
    {3'b101, 8'hA1, 8'h81, 4'b0000, 4'b0010, 1'b1, 8'hFF},
    {3'b110, 8'hA0, 8'h00, 4'b0001, 4'b0000, 1'b1, 8'h3C},
    {3'b110, 8'hA1, 8'h00, 4'b0010, 4'b0000, 1'b1, 8'h81},
    {3'b110, 8'hA2, 8'h00, 4'b0100, 4'b0000, 1'b1, 8'h5C},
    {3'b110, 8'hA3, 8'h00, 4'b1000, 4'b0000, 1'b1, 8'h96},
    {3'b110, 8'hA4, 8'h00, 4'b0000, 4'b0000, 1'b1, 8'hFF},
    {3'b110, 8'hA7, 8'h00, 4'b0000, 4'b0000, 1'b1, 8'hFF},
    {3'b101, 8'hA5, 8'h77, 4'b0000, 4'b0000, 1'b1, 8'hFF},
    {3'b110, 8'hA8, 8'h00, 4'b0000, 4'b0000, 1'b0, 8'hFF},
    {3'b110, 8'h9F, 8'h00, 4'b0000, 4'b0000, 1'b0, 8'hFF},
    {3'b111, 8'hA1, 8'h00, 4'b0000, 4'b0000, 1'b0, 8'hFF},
    {3'b001, 8'hA1, 8'h00, 4'b0000, 4'b0000, 1'b0, 8'hFF},
    {3'b100, 8'hA1, 8'h00, 4'b0000, 4'b0000, 1'b0, 8'hFF},
    {3'b110, 8'hA1, 8'h00, 4'b0010, 4'b0000, 1'b1, 8'h81}
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, din_ext = 8'h96, adc_result = 8'h5C;
  logic io_req = 0, rd = 0, wr = 0;
  logic [7:0] rdata, dac_data, dout;
  logic xcvr_en, conv_start, access_led;
  logic [3:0] port_rd_sel, port_wr_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  periph_bus_if #(.IND_CYCLES(LED_N)) i_periph_bus_if (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .io_req(io_req),
    .rd(rd), .wr(wr), .din_ext(din_ext), .adc_result(adc_result),
    .rdata(rdata), .xcvr_en(xcvr_en), .port_rd_sel(port_rd_sel),
    .port_wr_sel(port_wr_sel), .conv_start(conv_start), .dac_data(dac_data),
    .dout(dout), .access_led(access_led));

  task automatic check(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic i, r, w, input logic [7:0] a, d);
    @(negedge clk);
    io_req = i; rd = r; wr = w; addr = a; wdata = d;
    #1;
  endtask

  task automatic release_bus();
    @(negedge clk);
    io_req = 0; rd = 0; wr = 0;
    #1;
  endtask

  function automatic string vtag(input int i);
    case (i)
      0, 1, 8: return "R2 write decode";
      2, 3:    return "R7 readback";
      4:       return "R7 adc read";
      5:       return "R8 input read";
      6, 7:    return "R9 unused read";
      9, 10:   return "R1 outside window";
      14:      return "R5 latch held";
      default: return "R10 illegal strobes";
    endcase
  endfunction

  initial begin
    #2;
    check("R11 reset dout", {24'd0, dout}, 32'd0);
    check("R11 reset dac", {24'd0, dac_data}, 32'd0);
    check("R11 reset led", {31'd0, access_led}, 32'd0);
    check("R11 reset start", {31'd0, conv_start}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][35], VEC[i][34], VEC[i][33], VEC[i][32:25], VEC[i][24:17]);
      check(vtag(i), {15'd0, port_rd_sel, port_wr_sel, xcvr_en, rdata},
            {15'd0, VEC[i][16:0]});
      release_bus();
    end
    check("R5 dout port", {24'd0, dout}, 32'h81);
    check("R6 dac port", {24'd0, dac_data}, 32'h3C);

    // start pulse: one cycle, held write strobe of two cycles
    drive(1, 0, 1, 8'hA0, 8'h00);
    @(negedge clk); #1;
    check("R6 start high", {31'd0, conv_start}, 32'd1);
    release_bus();
    check("R6 start single", {31'd0, conv_start}, 32'd0);

    // input synchronizer: two edges of latency
    @(negedge clk); din_ext = 8'h69;
    drive(1, 1, 0, 8'hA3, 8'h00);
    check("R8 sync old value", {24'd0, rdata}, 32'h96);
    release_bus();
    drive(1, 1, 0, 8'hA3, 8'h00);
    check("R8 sync new value", {24'd0, rdata}, 32'h69);
    release_bus();

    // indicator length
    repeat (LED_N + 2) @(negedge clk);
    check("R3 led idle", {31'd0, access_led}, 32'd0);
    drive(1, 1, 0, 8'hA6, 8'h00);
    release_bus();
    check("R3 led on", {31'd0, access_led}, 32'd1);
    repeat (LED_N - 1) @(negedge clk);
    #1 check("R3 led last cycle", {31'd0, access_led}, 32'd1);
    @(negedge clk); #1;
    check("R3 led expired", {31'd0, access_led}, 32'd0);

    // retrigger
    drive(1, 0, 1, 8'hA7, 8'h00);
    release_bus();
    repeat (10) @(negedge clk);
    drive(1, 1, 0, 8'hA4, 8'h00);
    release_bus();
    repeat (LED_N - 1) @(negedge clk);
    #1 check("R3 led retriggered", {31'd0, access_led}, 32'd1);
    @(negedge clk); #1;
    check("R3 led retrigger end", {31'd0, access_led}, 32'd0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end
endmodule